// File: doc/BRIEF.md
# Private Interrupt Register Frame

This block is the per-core state store for 32 private interrupts. IDs 0 to 15 are software-generated: each has a one-cycle set strobe and a clear strobe. IDs 16 to 31 are private peripheral interrupts, driven by 16 level inputs. For each interrupt the block holds an enable bit, a pending bit, an active bit, a group bit and an 8-bit priority. It also holds two 32-bit configuration words. A 32-bit register port reads and writes all of this state. The enable, pending and active bitmaps each have two views at separate offsets: a set view and a clear view.

The block computes which interrupts are ready to forward. It then drives two registered request lines to the core: `irq` for group 1 and `fiq` for group 0. A separate enable input gates each line. The forwardable vector, the priority array and the group bits are also exported so that a CPU interface can choose and acknowledge the winner.

Top module: `priv_irq_frame`

## Requirements
- R1: Synchronous active-high reset clears every bitmap, group bit, priority and configuration word, and drives `irq` and `fiq` low. After reset every register reads zero.
- R2: A write to 0x0100 ORs the data into the enable bitmap. A write to 0x0180 clears every enable bit whose data bit is 1. Reading either offset returns the enable bitmap.
- R3: The pending bitmap uses the same set/clear rule at 0x0200 (set) and 0x0280 (clear). The active bitmap uses it at 0x0300 (set) and 0x0380 (clear). Both views of each bitmap read the same value.
- R4: Peripheral input n drives pending bit 16+n. A rising level sets the bit and a falling level clears it. The bit changes on the clock edge at which the new level is first sampled.
- R5: A pulse on software strobe set n sets pending bit n, and a pulse on clear n clears it. If both strobes are high for the same bit in one cycle, the bit ends up set.
- R6: A register write to the set-pending or clear-pending view takes precedence over an input event or strobe on the same bit in the same cycle.
- R7: `fwd_vec` equals pending AND enabled AND NOT active, bit by bit.
- R8: `irq` goes high one clock after some forwardable interrupt has group bit 1 while `grp1_en` is high. `fiq` goes high one clock after some forwardable interrupt has group bit 0 while `grp0_en` is high. Each line drops one clock after its condition stops holding.
- R9: Setting an interrupt active removes it from signalling. Clearing the active bit again restores the request.
- R10: The priority of interrupt i is the byte at bit 8*(i mod 4) of the word at offset 0x0400 + 4*(i div 4), for 8 words. `prio_vec[8*i+7:8*i]` carries the same byte.
- R11: A write to the group word at 0x0080 replaces all 32 group bits. `grp_vec` carries them.
- R12: The configuration words at 0x0C00 and 0x0C04 store and return any 32-bit value.
- R13: Only accesses with `req_size` = 2 (four bytes) at offsets whose two low bits are zero are taken. Any other access, and any access to an unmapped offset, reads zero and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code; 2 means four bytes |
| req_addr | input | 16 | Byte offset within the frame |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational, zero when no legal read |
| ppi_lvl | input | 16 | Private peripheral interrupt levels (IDs 16 to 31) |
| sgi_set | input | 16 | Software interrupt set strobes (IDs 0 to 15) |
| sgi_clr | input | 16 | Software interrupt clear strobes (IDs 0 to 15) |
| grp0_en | input | 1 | Group 0 signalling enable |
| grp1_en | input | 1 | Group 1 signalling enable |
| irq | output | 1 | Registered group 1 request |
| fiq | output | 1 | Registered group 0 request |
| fwd_vec | output | 32 | Pending AND enabled AND NOT active |
| prio_vec | output | 256 | Per-interrupt priorities, interrupt i in byte i |
| grp_vec | output | 32 | Per-interrupt group bits |

## Verification
The bench tests the cases where input events and register writes arrive in the same cycle. A clear-pending write lands on the same edge as a peripheral rising edge, and a set-pending write lands on a falling edge. A design that lets the input win would leave the wrong pending value in the register. It also raises set and clear strobes together on one software interrupt. The wrong priority there would drop the interrupt.

The bench marks an enabled interrupt active and expects its request to fall, then clears the active bit and expects the request back. A design that ignores the active bit would keep asserting the line. It samples `irq` on the edge right after pending changes, and again one edge later. This catches a design that is one cycle early or late. It also sends misaligned and wrong-size accesses, which a design with a loose decoder would accept as writes.

// File: rtl/priv_irq_pkg.sv
package priv_irq_pkg;

    localparam int NUM_SW        = 16;
    localparam int NUM_PPI       = 16;
    localparam int NUM_INT       = NUM_SW + NUM_PPI;
    localparam int PRIO_W        = 8;
    localparam int WORD_W        = 32;
    localparam int ADDR_W        = 16;
    localparam int PRIO_PER_WORD = WORD_W / PRIO_W;
    localparam int PRIO_WORDS    = NUM_INT / PRIO_PER_WORD;
    localparam int PW_IDX_W      = $clog2(PRIO_WORDS);

    localparam logic [1:0] SIZE_WORD = 2'd2;

    localparam logic [ADDR_W-1:0] OFF_GROUP  = 16'h0080;
    localparam logic [ADDR_W-1:0] OFF_EN_SET = 16'h0100;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR = 16'h0180;
    localparam logic [ADDR_W-1:0] OFF_PD_SET = 16'h0200;
    localparam logic [ADDR_W-1:0] OFF_PD_CLR = 16'h0280;
    localparam logic [ADDR_W-1:0] OFF_AC_SET = 16'h0300;
    localparam logic [ADDR_W-1:0] OFF_AC_CLR = 16'h0380;
    localparam logic [ADDR_W-1:0] OFF_PRIO   = 16'h0400;
    localparam logic [ADDR_W-1:0] OFF_CFG0   = 16'h0C00;
    localparam logic [ADDR_W-1:0] OFF_CFG1   = 16'h0C04;
    localparam logic [ADDR_W-1:0] PRIO_END   = OFF_PRIO + ADDR_W'(PRIO_WORDS * 4);

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_GROUP,
        ACC_EN_SET,
        ACC_EN_CLR,
        ACC_PD_SET,
        ACC_PD_CLR,
        ACC_AC_SET,
        ACC_AC_CLR,
        ACC_PRIO,
        ACC_CFG0,
        ACC_CFG1
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e             kind;
        logic [PW_IDX_W-1:0]   word;
    } acc_dec_t;

    // An access is taken only as a four-byte access on a word boundary.
    function automatic logic access_legal(logic [1:0] size, logic [ADDR_W-1:0] addr);
        return (size == SIZE_WORD) && (addr[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/priv_irq_decode.sv
module priv_irq_decode
    import priv_irq_pkg::*;
(
    input  logic              req_valid,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    output acc_dec_t          dec
);
    logic [ADDR_W-1:0] prio_off;

    assign prio_off = req_addr - OFF_PRIO;

    always_comb begin
        dec.kind = ACC_NONE;
        dec.word = '0;
        if (req_valid && access_legal(req_size, req_addr)) begin
            case (req_addr)
                OFF_GROUP:  dec.kind = ACC_GROUP;
                OFF_EN_SET: dec.kind = ACC_EN_SET;
                OFF_EN_CLR: dec.kind = ACC_EN_CLR;
                OFF_PD_SET: dec.kind = ACC_PD_SET;
                OFF_PD_CLR: dec.kind = ACC_PD_CLR;
                OFF_AC_SET: dec.kind = ACC_AC_SET;
                OFF_AC_CLR: dec.kind = ACC_AC_CLR;
                OFF_CFG0:   dec.kind = ACC_CFG0;
                OFF_CFG1:   dec.kind = ACC_CFG1;
                default: begin
                    if (req_addr >= OFF_PRIO && req_addr < PRIO_END) begin
                        dec.kind = ACC_PRIO;
                        dec.word = prio_off[2 +: PW_IDX_W];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/priv_irq_bitmap.sv
module priv_irq_bitmap #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev_set,
    input  logic [W-1:0] ev_clr,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] bits
);
    logic [W-1:0] after_ev;
    logic [W-1:0] nxt;

    // Hardware events first, register write applied last so it wins per bit.
    always_comb begin
        after_ev = (bits | ev_set) & ~ev_clr;
        nxt      = after_ev;
        if (wr_set) nxt = nxt | wdata;
        if (wr_clr) nxt = nxt & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) bits <= '0;
        else     bits <= nxt;
    end
endmodule

// File: rtl/priv_irq_signal.sv
module priv_irq_signal #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] en,
    input  logic [W-1:0] act,
    input  logic [W-1:0] grp,
    input  logic         grp0_en,
    input  logic         grp1_en,
    output logic [W-1:0] fwd,
    output logic         irq,
    output logic         fiq
);
    assign fwd = pend & en & ~act;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            fiq <= 1'b0;
        end else begin
            irq <= grp1_en && (|(fwd & grp));
            fiq <= grp0_en && (|(fwd & ~grp));
        end
    end
endmodule

// File: rtl/priv_irq_frame.sv
module priv_irq_frame
    import priv_irq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [1:0]                req_size,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [WORD_W-1:0]         req_wdata,
    output logic [WORD_W-1:0]         rd_data,
    input  logic [NUM_PPI-1:0]        ppi_lvl,
    input  logic [NUM_SW-1:0]         sgi_set,
    input  logic [NUM_SW-1:0]         sgi_clr,
    input  logic                      grp0_en,
    input  logic                      grp1_en,
    output logic                      irq,
    output logic                      fiq,
    output logic [NUM_INT-1:0]        fwd_vec,
    output logic [NUM_INT*PRIO_W-1:0] prio_vec,
    output logic [NUM_INT-1:0]        grp_vec
);
    acc_dec_t            dec;
    logic                wr;
    logic [NUM_PPI-1:0]  ppi_q;
    logic [NUM_PPI-1:0]  ppi_rise;
    logic [NUM_PPI-1:0]  ppi_fall;
    logic [NUM_INT-1:0]  en_bits;
    logic [NUM_INT-1:0]  pend_bits;
    logic [NUM_INT-1:0]  act_bits;
    logic [NUM_INT-1:0]  grp_q;
    logic [WORD_W-1:0]   cfg0_q;
    logic [WORD_W-1:0]   cfg1_q;
    logic [PRIO_W-1:0]   prio_q    [NUM_INT];
    logic [WORD_W-1:0]   prio_word [PRIO_WORDS];

    priv_irq_decode u_dec (
        .req_valid (req_valid),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .dec       (dec)
    );

    assign wr = req_valid && req_write;

    always_ff @(posedge clk) begin
        if (rst) ppi_q <= '0;
        else     ppi_q <= ppi_lvl;
    end

    assign ppi_rise = ppi_lvl & ~ppi_q;
    assign ppi_fall = ~ppi_lvl & ppi_q;

    priv_irq_bitmap #(.W(NUM_INT)) u_en (
        .clk    (clk),
        .rst    (rst),
        .ev_set ('0),
        .ev_clr ('0),
        .wr_set (wr && dec.kind == ACC_EN_SET),
        .wr_clr (wr && dec.kind == ACC_EN_CLR),
        .wdata  (req_wdata),
        .bits   (en_bits)
    );

    priv_irq_bitmap #(.W(NUM_INT)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .ev_set ({ppi_rise, sgi_set}),
        .ev_clr ({ppi_fall, sgi_clr & ~sgi_set}),
        .wr_set (wr && dec.kind == ACC_PD_SET),
        .wr_clr (wr && dec.kind == ACC_PD_CLR),
        .wdata  (req_wdata),
        .bits   (pend_bits)
    );

    priv_irq_bitmap #(.W(NUM_INT)) u_act (
        .clk    (clk),
        .rst    (rst),
        .ev_set ('0),
        .ev_clr ('0),
        .wr_set (wr && dec.kind == ACC_AC_SET),
        .wr_clr (wr && dec.kind == ACC_AC_CLR),
        .wdata  (req_wdata),
        .bits   (act_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q  <= '0;
            cfg0_q <= '0;
            cfg1_q <= '0;
        end else if (wr) begin
            if (dec.kind == ACC_GROUP) grp_q  <= req_wdata;
            if (dec.kind == ACC_CFG0)  cfg0_q <= req_wdata;
            if (dec.kind == ACC_CFG1)  cfg1_q <= req_wdata;
        end
    end

    for (genvar i = 0; i < NUM_INT; i++) begin : g_prio
        localparam int WIDX = i / PRIO_PER_WORD;
        localparam int LANE = i % PRIO_PER_WORD;
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[i] <= '0;
            else if (wr && dec.kind == ACC_PRIO && dec.word == PW_IDX_W'(WIDX))
                prio_q[i] <= req_wdata[LANE*PRIO_W +: PRIO_W];
        end
        assign prio_vec[i*PRIO_W +: PRIO_W]           = prio_q[i];
        assign prio_word[WIDX][LANE*PRIO_W +: PRIO_W] = prio_q[i];
    end

    priv_irq_signal #(.W(NUM_INT)) u_sig (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend_bits),
        .en      (en_bits),
        .act     (act_bits),
        .grp     (grp_q),
        .grp0_en (grp0_en),
        .grp1_en (grp1_en),
        .fwd     (fwd_vec),
        .irq     (irq),
        .fiq     (fiq)
    );

    assign grp_vec = grp_q;

    always_comb begin
        rd_data = '0;
        if (req_valid && !req_write) begin
            case (dec.kind)
                ACC_GROUP:              rd_data = grp_q;
                ACC_EN_SET, ACC_EN_CLR: rd_data = en_bits;
                ACC_PD_SET, ACC_PD_CLR: rd_data = pend_bits;
                ACC_AC_SET, ACC_AC_CLR: rd_data = act_bits;
                ACC_PRIO:               rd_data = prio_word[dec.word];
                ACC_CFG0:               rd_data = cfg0_q;
                ACC_CFG1:               rd_data = cfg1_q;
                default:                rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/priv_irq_frame_chk.sv
module priv_irq_frame_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic [15:0] req_addr,
    input logic [31:0] req_wdata,
    input logic [15:0] ppi_lvl,
    input logic [15:0] ppi_q,
    input logic        grp0_en,
    input logic        grp1_en,
    input logic        irq,
    input logic        fiq,
    input logic [31:0] fwd_vec,
    input logic [31:0] grp_vec,
    input logic [31:0] en_bits,
    input logic [31:0] pend_bits,
    input logic [31:0] act_bits
);
    logic        armed;
    logic [15:0] rise;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assign rise = ppi_lvl & ~ppi_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq && !fiq && fwd_vec == 32'h0));

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (irq == $past(grp1_en && (|(fwd_vec & grp_vec)))));

    // R8
    fiq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (fiq == $past(grp0_en && (|(fwd_vec & ~grp_vec)))));

    // R2
    en_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size == 2'd2 && req_addr == 16'h0180)
        |=> ((en_bits & $past(req_wdata)) == 32'h0));

    // R4
    ppi_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !(req_valid && req_write) && (|rise))
        |=> ((pend_bits[31:16] & $past(rise)) == $past(rise)));

    // R13
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && req_valid && req_write && req_size != 2'd2)
        |=> ($stable(en_bits) && $stable(act_bits) && $stable(grp_vec)));
endmodule

bind priv_irq_frame priv_irq_frame_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ppi_lvl   (ppi_lvl),
    .ppi_q     (ppi_q),
    .grp0_en   (grp0_en),
    .grp1_en   (grp1_en),
    .irq       (irq),
    .fiq       (fiq),
    .fwd_vec   (fwd_vec),
    .grp_vec   (grp_vec),
    .en_bits   (en_bits),
    .pend_bits (pend_bits),
    .act_bits  (act_bits)
);

// File: tb/priv_irq_frame_tb_top.sv
module priv_irq_frame_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [1:0]   req_size = 2'd2;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [31:0]  rd_data;
    logic [15:0]  ppi_lvl = '0;
    logic [15:0]  sgi_set = '0;
    logic [15:0]  sgi_clr = '0;
    logic         grp0_en = 1'b0;
    logic         grp1_en = 1'b0;
    logic         irq;
    logic         fiq;
    logic [31:0]  fwd_vec;
    logic [255:0] prio_vec;
    logic [31:0]  grp_vec;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    priv_irq_frame dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .ppi_lvl(ppi_lvl), .sgi_set(sgi_set), .sgi_clr(sgi_clr),
        .grp0_en(grp0_en), .grp1_en(grp1_en),
        .irq(irq), .fiq(fiq), .fwd_vec(fwd_vec),
        .prio_vec(prio_vec), .grp_vec(grp_vec)
    );

    // {write, offset, data}: data is write data for writes, expected value for reads
    localparam int NV = 25;
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 16'h0100, 32'h000000F0},
        {1'b0, 16'h0100, 32'h000000F0},
        {1'b0, 16'h0180, 32'h000000F0},
        {1'b1, 16'h0180, 32'h00000030},
        {1'b0, 16'h0100, 32'h000000C0},
        {1'b1, 16'h0200, 32'hFF000001},
        {1'b0, 16'h0280, 32'hFF000001},
        {1'b1, 16'h0280, 32'h0F000000},
        {1'b0, 16'h0200, 32'hF0000001},
        {1'b1, 16'h0300, 32'h00000081},
        {1'b0, 16'h0380, 32'h00000081},
        {1'b1, 16'h0380, 32'h00000001},
        {1'b0, 16'h0300, 32'h00000080},
        {1'b1, 16'h0408, 32'h44332211},
        {1'b0, 16'h0408, 32'h44332211},
        {1'b1, 16'h0C00, 32'hA5A55A5A},
        {1'b0, 16'h0C00, 32'hA5A55A5A},
        {1'b1, 16'h0C04, 32'h12345678},
        {1'b0, 16'h0C04, 32'h12345678},
        {1'b1, 16'h0080, 32'hFFFF0000},
        {1'b1, 16'h0080, 32'h000000FF},
        {1'b0, 16'h0080, 32'h000000FF},
        {1'b1, 16'h0500, 32'hDEADBEEF},
        {1'b0, 16'h0500, 32'h00000000},
        {1'b0, 16'h040C, 32'h00000000}
    };

    function automatic string tag_of(logic [15:0] a);
        if (a == 16'h0100 || a == 16'h0180)        return "R2";
        if (a >= 16'h0200 && a <= 16'h0380)        return "R3";
        if (a >= 16'h0400 && a < 16'h0420)         return "R10";
        if (a == 16'h0C00 || a == 16'h0C04)        return "R12";
        if (a == 16'h0080)                         return "R11";
        return "R13";
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        #1;
        d = rd_data;
        req_valid = 1'b0; req_size = 2'd2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Register behaviour table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][48]) begin
                wr(VEC[i][47:32], VEC[i][31:0]);
            end else begin
                rd(VEC[i][47:32], d);
                check(tag_of(VEC[i][47:32]), 256'(d), 256'(VEC[i][31:0]));
            end
        end

        // R1: everything back to zero after reset
        do_reset();
        @(negedge clk);
        rd(16'h0100, d); check("R1", 256'(d), 256'h0);
        rd(16'h0200, d); check("R1", 256'(d), 256'h0);
        rd(16'h0300, d); check("R1", 256'(d), 256'h0);
        rd(16'h0080, d); check("R1", 256'(d), 256'h0);
        rd(16'h0C00, d); check("R1", 256'(d), 256'h0);
        rd(16'h0408, d); check("R1", 256'(d), 256'h0);
        check("R1", 256'({irq, fiq}), 256'h0);
        check("R1", 256'(fwd_vec), 256'h0);
        check("R1", prio_vec, 256'h0);
        check("R1", 256'(grp_vec), 256'h0);

        // R10: exported byte order
        wr(16'h0404, 32'hDDCCBBAA);
        check("R10", 256'(prio_vec[4*8 +: 8]), 256'hAA);
        check("R10", 256'(prio_vec[7*8 +: 8]), 256'hDD);
        check("R10", 256'(prio_vec[3*8 +: 8]), 256'h0);

        // R13: wrong size, misaligned, wrong-size read
        wr(16'h0100, 32'h0000FFFF, 2'd1);
        rd(16'h0100, d); check("R13", 256'(d), 256'h0);
        wr(16'h0102, 32'h0000FFFF);
        rd(16'h0100, d); check("R13", 256'(d), 256'h0);
        rd(16'h0404, d, 2'd1); check("R13", 256'(d), 256'h0);

        // R4: peripheral level edges
        @(negedge clk); ppi_lvl[3] = 1'b1;
        rd(16'h0200, d); check("R4", 256'(d), 256'h00080000);
        @(negedge clk); ppi_lvl[3] = 1'b0;
        rd(16'h0200, d); check("R4", 256'(d), 256'h0);

        // R5: strobes, set wins over clear
        @(negedge clk); sgi_set = 16'h0060; sgi_clr = 16'h0040;
        @(negedge clk); sgi_set = '0; sgi_clr = '0;
        rd(16'h0200, d); check("R5", 256'(d), 256'h60);
        @(negedge clk); sgi_clr = 16'h0020;
        @(negedge clk); sgi_clr = '0;
        rd(16'h0200, d); check("R5", 256'(d), 256'h40);
        wr(16'h0280, 32'hFFFFFFFF);

        // R6: register write beats a same-cycle input edge
        @(negedge clk);
        ppi_lvl[0] = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0280; req_wdata = 32'h00010000;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd(16'h0200, d); check("R6", 256'(d), 256'h0);
        @(negedge clk);
        ppi_lvl[0] = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0200; req_wdata = 32'h00010000;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd(16'h0200, d); check("R6", 256'(d), 256'h00010000);
        wr(16'h0280, 32'hFFFFFFFF);

        // R7 / R8: forwarding and registered request lines
        wr(16'h0080, 32'h00000004);
        check("R11", 256'(grp_vec), 256'h4);
        wr(16'h0100, 32'h00000204);
        @(negedge clk); grp1_en = 1'b1; grp0_en = 1'b0; sgi_set = 16'h0204;
        @(negedge clk); sgi_set = '0;
        check("R8", 256'(irq), 256'h0);
        @(negedge clk);
        check("R8", 256'({irq, fiq}), 256'h2);
        check("R7", 256'(fwd_vec), 256'h204);
        grp0_en = 1'b1;
        @(negedge clk);
        check("R8", 256'(fiq), 256'h1);

        // R9: active interrupts are not signalled
        wr(16'h0300, 32'h00000004);
        @(negedge clk);
        check("R9", 256'({irq, fiq}), 256'h1);
        check("R7", 256'(fwd_vec), 256'h200);
        wr(16'h0380, 32'h00000004);
        @(negedge clk);
        check("R9", 256'(irq), 256'h1);

        // R8: group enable removal drops the line
        grp1_en = 1'b0;
        @(negedge clk);
        check("R8", 256'({irq, fiq}), 256'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule